// File: doc/BRIEF.md
# Context-Driven Array Processing Element

This block is one tile of a mesh of word-level compute elements. On each enabled clock it runs one operation on a 16-bit datapath. A locally held context word, picked by a context pointer, chooses the operation, the source of each of the three operands, the register-file reads and writes, the routing read, and the predicate that guards the cycle. Operands may come from the element's own data register file, from two row memory buses, from four neighbour elements, or from its own previous result. Bus and neighbour values feed the functional unit in the same cycle without first landing in storage.

Before a loop runs, context words are written into the store through a configuration port. While `run` is high the pointer steps through entries 0 to `ctx_last` and wraps, so one context is issued per cycle at no switching cost. The data and predicate register files both rotate. An iteration strobe advances their common base, so software-pipelined iterations see renamed registers. Results leave toward the neighbours on a data output and a predicate output. A second data output carries a register-file value read through a fourth read port.

Top module: `cgra_cell`

## Requirements
- R1: After reset, `data_out`, `pred_out`, `route_out` and `ctx_ptr` are 0, and every data register, predicate register and context word is 0. An all-zero context passes register 0 to the output.
- R2: While `cfg_we` is high, `cfg_word` is stored at `cfg_addr`. While `run` is high, `ctx_ptr` goes to 0 on the clock after it equals `ctx_last` and otherwise increases by one. While `run` is low it holds. The context word layout is: op [3:0], A source [6:4], A register [10:7], B source [13:11], B register [17:14], C source [20:18], C register [24:21], port-0 write enable [25], port-0 register [29:26], port-1 write enable [30], port-1 source [33:31], port-1 register [37:34], route register [41:38], guard mode [43:42], guard index [47:44], predicate write enable [48], predicate register [52:49].
- R3: Every operation completes in one cycle. `data_out` shows the result on the clock after the context is issued. The op codes are: 0 pass A, 1 A+B, 2 A-B, 3 AND, 4 OR, 5 XOR, 6 low half of A*B, 7 A shifted left by B[3:0], 8 logical right shift, 9 arithmetic right shift, 10 compare less-than signed (result A), 11 compare equal (result A), 12 A*B+C, 13 select A if C is nonzero else B, 14 signed minimum, 15 A+B+C.
- R4: For ops 10, 11 and 14 the predicate is signed A<B, A==B and signed A<B respectively. For op 13 it is (C != 0). For every other op it is (result != 0). It appears on `pred_out` together with the data result.
- R5: The source codes are: 0 register file, 1 bus 0, 2 bus 1, 3 to 6 neighbours 0 to 3, 7 the element's own `data_out`. Bus and neighbour values are used in the cycle they are presented.
- R6: The data file has two write ports. Port 0 writes the result. Port 1 writes the value its own source field selects, where code 0 means the route-register read. When both ports hit the same physical register, port 0 wins. A read in the cycle of a write returns the old value.
- R7: Each `iter_adv` pulse adds one, modulo 16, to the rotation base. Physical register = logical + base. A value written at logical L is read at logical L-1 after one advance, and at L again after 16 advances.
- R8: Guard modes are: 0 always, 1 predicate register true, 2 predicate register false, 3 neighbour predicate `nb_pred[index[1:0]]` true. A false guard suppresses all register writes and holds all three outputs.
- R9: When enabled, the predicate result is written into the rotating predicate file, which uses the same base as the data file.
- R10: `route_out` registers the data-file value at the route register on each executed cycle.
- R11: Source code 7 feeds the previous `data_out` back as an operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Context store write strobe |
| cfg_addr | input | 4 | Context store write index |
| cfg_word | input | 53 | Context word to store |
| run | input | 1 | Issue the current context and step the pointer |
| ctx_last | input | 4 | Last context index before wrapping to 0 |
| iter_adv | input | 1 | Advance the rotation base of both register files |
| bus_in | input | 32 | Row bus words, bus 0 in the low half |
| nb_in | input | 64 | Neighbour words, neighbour 0 in the low 16 bits |
| nb_pred | input | 4 | Neighbour predicate bits |
| data_out | output | 16 | Registered result toward neighbours |
| pred_out | output | 1 | Registered predicate toward neighbours |
| route_out | output | 16 | Registered register-file value for forwarding |
| ctx_ptr | output | 4 | Current context pointer |

## Verification
The bench builds the element with its default parameters: 16-bit words and 16 entries each in the data file, predicate file and context store. Because the files are only 16 entries deep, a full lap of the rotation base fits in sixteen strobes, so the wrap back to the original physical register can be checked directly. The narrow context index lets a short program exercise the pointer wrap at a chosen `ctx_last`. The 4-bit shift field covers every shift amount of the word, and all sixteen op codes are run over operand sets that include sign bits, all-ones and zero.

// File: rtl/cgra_cell.sv
`timescale 1ns/1ps
module cgra_cell #(
  parameter int DW = 16,
  parameter int RF_DEPTH = 16,
  parameter int PRF_DEPTH = 16,
  parameter int CTX_DEPTH = 16,
  localparam int AW = $clog2(RF_DEPTH),
  localparam int PW = $clog2(PRF_DEPTH),
  localparam int CAW = $clog2(CTX_DEPTH),
  localparam int SHW = $clog2(DW),
  localparam int SW = 3,
  localparam int OPW = 4,
  localparam int A_SRC = OPW,
  localparam int A_ADR = A_SRC + SW,
  localparam int B_SRC = A_ADR + AW,
  localparam int B_ADR = B_SRC + SW,
  localparam int C_SRC = B_ADR + AW,
  localparam int C_ADR = C_SRC + SW,
  localparam int W0_EN = C_ADR + AW,
  localparam int W0_ADR = W0_EN + 1,
  localparam int W1_EN = W0_ADR + AW,
  localparam int W1_SRC = W1_EN + 1,
  localparam int W1_ADR = W1_SRC + SW,
  localparam int R3_ADR = W1_ADR + AW,
  localparam int G_MODE = R3_ADR + AW,
  localparam int G_ADR = G_MODE + 2,
  localparam int PW_EN = G_ADR + PW,
  localparam int PW_ADR = PW_EN + 1,
  localparam int CW = PW_ADR + PW
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CAW-1:0]    cfg_addr,
  input  logic [CW-1:0]     cfg_word,
  input  logic              run,
  input  logic [CAW-1:0]    ctx_last,
  input  logic              iter_adv,
  input  logic [2*DW-1:0]   bus_in,
  input  logic [4*DW-1:0]   nb_in,
  input  logic [3:0]        nb_pred,
  output logic [DW-1:0]     data_out,
  output logic              pred_out,
  output logic [DW-1:0]     route_out,
  output logic [CAW-1:0]    ctx_ptr
);

  logic [CW-1:0]    ctx_mem [CTX_DEPTH];
  logic [CAW-1:0]   ctx_q;
  logic [DW-1:0]    rf [RF_DEPTH];
  logic [PRF_DEPTH-1:0] prf;
  logic [AW-1:0]    rbase;
  logic [PW-1:0]    pbase;
  logic [DW-1:0]    dout_q, route_q;
  logic             pout_q;

  logic [CW-1:0]    cw;
  assign cw = ctx_mem[ctx_q];

  logic [OPW-1:0] op;
  logic [SW-1:0]  a_src, b_src, c_src, w1_src;
  logic [AW-1:0]  a_adr, b_adr, c_adr, w0_adr, w1_adr, r3_adr;
  logic           w0_en, w1_en, pw_en;
  logic [1:0]     g_mode;
  logic [PW-1:0]  g_adr, pw_adr;

  assign op     = cw[0 +: OPW];
  assign a_src  = cw[A_SRC +: SW];
  assign a_adr  = cw[A_ADR +: AW];
  assign b_src  = cw[B_SRC +: SW];
  assign b_adr  = cw[B_ADR +: AW];
  assign c_src  = cw[C_SRC +: SW];
  assign c_adr  = cw[C_ADR +: AW];
  assign w0_en  = cw[W0_EN];
  assign w0_adr = cw[W0_ADR +: AW];
  assign w1_en  = cw[W1_EN];
  assign w1_src = cw[W1_SRC +: SW];
  assign w1_adr = cw[W1_ADR +: AW];
  assign r3_adr = cw[R3_ADR +: AW];
  assign g_mode = cw[G_MODE +: 2];
  assign g_adr  = cw[G_ADR +: PW];
  assign pw_en  = cw[PW_EN];
  assign pw_adr = cw[PW_ADR +: PW];

  logic [AW-1:0] a_ph, b_ph, c_ph, w0_ph, w1_ph, r3_ph;
  logic [PW-1:0] g_ph, pw_ph;
  assign a_ph  = a_adr + rbase;
  assign b_ph  = b_adr + rbase;
  assign c_ph  = c_adr + rbase;
  assign w0_ph = w0_adr + rbase;
  assign w1_ph = w1_adr + rbase;
  assign r3_ph = r3_adr + rbase;
  assign g_ph  = g_adr + pbase;
  assign pw_ph = pw_adr + pbase;

  logic [DW-1:0] rd3;
  assign rd3 = rf[r3_ph];

  function automatic logic [DW-1:0] pick(input logic [SW-1:0] s, input logic [DW-1:0] rfv,
                                         input logic [2*DW-1:0] bus, input logic [4*DW-1:0] nb,
                                         input logic [DW-1:0] fb);
    case (s)
      3'd0:    return rfv;
      3'd1:    return bus[0 +: DW];
      3'd2:    return bus[DW +: DW];
      3'd3:    return nb[0 +: DW];
      3'd4:    return nb[DW +: DW];
      3'd5:    return nb[2*DW +: DW];
      3'd6:    return nb[3*DW +: DW];
      default: return fb;
    endcase
  endfunction

  logic [DW-1:0] opa, opb, opc, w1_val;
  assign opa    = pick(a_src, rf[a_ph], bus_in, nb_in, dout_q);
  assign opb    = pick(b_src, rf[b_ph], bus_in, nb_in, dout_q);
  assign opc    = pick(c_src, rf[c_ph], bus_in, nb_in, dout_q);
  assign w1_val = pick(w1_src, rd3, bus_in, nb_in, dout_q);

  logic [DW-1:0]  mul_lo;
  logic [SHW-1:0] sh;
  logic           lt;
  assign mul_lo = opa * opb;
  assign sh     = opb[SHW-1:0];
  assign lt     = $signed(opa) < $signed(opb);

  logic [DW-1:0] fu_r;
  logic          fu_p, cmp;
  always_comb begin
    fu_r = opa;
    fu_p = 1'b0;
    cmp  = 1'b0;
    case (op)
      4'd0:  fu_r = opa;
      4'd1:  fu_r = opa + opb;
      4'd2:  fu_r = opa - opb;
      4'd3:  fu_r = opa & opb;
      4'd4:  fu_r = opa | opb;
      4'd5:  fu_r = opa ^ opb;
      4'd6:  fu_r = mul_lo;
      4'd7:  fu_r = opa << sh;
      4'd8:  fu_r = opa >> sh;
      4'd9:  fu_r = DW'($signed(opa) >>> sh);
      4'd10: begin fu_r = opa; cmp = 1'b1; fu_p = lt; end
      4'd11: begin fu_r = opa; cmp = 1'b1; fu_p = (opa == opb); end
      4'd12: fu_r = mul_lo + opc;
      4'd13: begin cmp = 1'b1; fu_p = |opc; fu_r = fu_p ? opa : opb; end
      4'd14: begin cmp = 1'b1; fu_p = lt; fu_r = lt ? opa : opb; end
      default: fu_r = opa + opb + opc;
    endcase
    if (!cmp) fu_p = |fu_r;
  end

  logic guard, fire;
  always_comb begin
    case (g_mode)
      2'd0:    guard = 1'b1;
      2'd1:    guard = prf[g_ph];
      2'd2:    guard = ~prf[g_ph];
      default: guard = nb_pred[g_adr[1:0]];
    endcase
  end
  assign fire = run & guard;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < CTX_DEPTH; i++) ctx_mem[i] <= '0;
    end else if (cfg_we) begin
      ctx_mem[cfg_addr] <= cfg_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctx_q <= '0;
      rbase <= '0;
      pbase <= '0;
    end else begin
      if (run) ctx_q <= (ctx_q == ctx_last) ? '0 : ctx_q + 1'b1;
      if (iter_adv) begin
        rbase <= rbase + 1'b1;
        pbase <= pbase + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < RF_DEPTH; i++) rf[i] <= '0;
      prf     <= '0;
      dout_q  <= '0;
      pout_q  <= 1'b0;
      route_q <= '0;
    end else if (fire) begin
      dout_q  <= fu_r;
      pout_q  <= fu_p;
      route_q <= rd3;
      if (w1_en && !(w0_en && w0_ph == w1_ph)) rf[w1_ph] <= w1_val;
      if (w0_en) rf[w0_ph] <= fu_r;
      if (pw_en) prf[pw_ph] <= fu_p;
    end
  end

  assign data_out  = dout_q;
  assign pred_out  = pout_q;
  assign route_out = route_q;
  assign ctx_ptr   = ctx_q;

  assert_ctx_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run && ctx_ptr == ctx_last |=> ctx_ptr == '0);
  assert_ctx_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run && ctx_ptr != ctx_last |=> ctx_ptr == CAW'($past(ctx_ptr) + 1'b1));
  assert_ctx_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(ctx_ptr));
  assert_guard_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(data_out) && $stable(pred_out) && $stable(route_out));
  assert_rot_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    iter_adv |=> rbase == AW'($past(rbase) + 1'b1));
  assert_bus_bypass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fire && op == 4'd0 && a_src == 3'd1 |=> data_out == $past(bus_in[DW-1:0]));
  assert_feedback_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fire && op == 4'd0 && a_src == 3'd7 |=> $stable(data_out));

endmodule

// File: tb/cgra_cell_tb_top.sv
`timescale 1ns/1ps
module cgra_cell_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [52:0] cfg_word = '0;
  logic        run = 1'b0;
  logic [3:0]  ctx_last = '0;
  logic        iter_adv = 1'b0;
  logic [31:0] bus_in = '0;
  logic [63:0] nb_in = '0;
  logic [3:0]  nb_pred = '0;
  logic [15:0] data_out, route_out;
  logic        pred_out;
  logic [3:0]  ctx_ptr;

  int total = 0;
  int bad = 0;

  localparam int S_RF = 0, S_B0 = 1, S_B1 = 2, S_N0 = 3, S_N1 = 4, S_N2 = 5, S_N3 = 6, S_FB = 7;

  cgra_cell dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_word(cfg_word),
    .run(run), .ctx_last(ctx_last), .iter_adv(iter_adv), .bus_in(bus_in), .nb_in(nb_in),
    .nb_pred(nb_pred), .data_out(data_out), .pred_out(pred_out), .route_out(route_out),
    .ctx_ptr(ctx_ptr)
  );

  always #4 clk = ~clk;

  function automatic logic [52:0] mk(input int op, input int as, input int aa, input int bs,
      input int ba, input int cs, input int ca, input int w0e, input int w0a, input int w1e,
      input int w1s, input int w1a, input int r3, input int gm, input int ga, input int pe,
      input int pa);
    logic [52:0] w;
    w = '0;
    w[3:0] = op[3:0];   w[6:4] = as[2:0];   w[10:7] = aa[3:0];
    w[13:11] = bs[2:0]; w[17:14] = ba[3:0]; w[20:18] = cs[2:0]; w[24:21] = ca[3:0];
    w[25] = w0e[0];     w[29:26] = w0a[3:0];
    w[30] = w1e[0];     w[33:31] = w1s[2:0]; w[37:34] = w1a[3:0];
    w[41:38] = r3[3:0]; w[43:42] = gm[1:0]; w[47:44] = ga[3:0];
    w[48] = pe[0];      w[52:49] = pa[3:0];
    return w;
  endfunction

  function automatic logic [16:0] ref_fu(input logic [3:0] op, input logic [15:0] a,
                                         input logic [15:0] b, input logic [15:0] c);
    logic [15:0] r;
    logic p, cmp;
    r = a; p = 1'b0; cmp = 1'b0;
    case (op)
      4'd1: r = a + b;
      4'd2: r = a - b;
      4'd3: r = a & b;
      4'd4: r = a | b;
      4'd5: r = a ^ b;
      4'd6: r = a * b;
      4'd7: r = a << b[3:0];
      4'd8: r = a >> b[3:0];
      4'd9: r = $signed(a) >>> b[3:0];
      4'd10: begin cmp = 1'b1; p = $signed(a) < $signed(b); end
      4'd11: begin cmp = 1'b1; p = (a == b); end
      4'd12: r = a * b + c;
      4'd13: begin cmp = 1'b1; p = (c != 0); r = p ? a : b; end
      4'd14: begin cmp = 1'b1; p = $signed(a) < $signed(b); r = p ? a : b; end
      4'd15: r = a + b + c;
      default: r = a;
    endcase
    if (!cmp) p = (r != 0);
    return {p, r};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; run = 1'b0; cfg_we = 1'b0; iter_adv = 1'b0;
    bus_in = '0; nb_in = '0; nb_pred = '0; ctx_last = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic load(input int addr, input logic [52:0] w);
    cfg_we = 1'b1; cfg_addr = addr[3:0]; cfg_word = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic step_chk(input string req, input logic [15:0] exp_d, input logic exp_p);
    @(negedge clk);
    chk(req, "data_out", 32'(data_out), 32'(exp_d));
    chk(req, "pred_out", 32'(pred_out), 32'(exp_p));
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "data_out", 32'(data_out), 0);
    chk("R1", "pred_out", 32'(pred_out), 0);
    chk("R1", "route_out", 32'(route_out), 0);
    chk("R1", "ctx_ptr", 32'(ctx_ptr), 0);
    run = 1'b1;
    @(negedge clk);
    run = 1'b0;
    chk("R1", "zero context result", 32'(data_out), 0);
    chk("R1", "ctx_ptr after run with last 0", 32'(ctx_ptr), 0);
  endtask

  task automatic t_ops();
    logic [15:0] va [3], vb [3], vc [3];
    logic [16:0] e;
    va[0] = 16'h1234; vb[0] = 16'h0F0F; vc[0] = 16'h0003;
    va[1] = 16'h8001; vb[1] = 16'h0004; vc[1] = 16'hFFFF;
    va[2] = 16'hFFFF; vb[2] = 16'hFFFF; vc[2] = 16'h0000;
    do_reset();
    for (int v = 0; v < 3; v++) begin
      for (int op = 0; op < 16; op++) begin
        load(0, mk(op, S_B0, 0, S_B1, 0, S_N0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        bus_in = {vb[v], va[v]};
        nb_in = {48'h0, vc[v]};
        run = 1'b1;
        @(negedge clk);
        run = 1'b0;
        e = ref_fu(op[3:0], va[v], vb[v], vc[v]);
        chk("R3", $sformatf("op %0d vec %0d data", op, v), 32'(data_out), 32'(e[15:0]));
        chk("R4", $sformatf("op %0d vec %0d pred", op, v), 32'(pred_out), 32'(e[16]));
      end
    end
  endtask

  task automatic t_ctx();
    do_reset();
    load(0, mk(0, S_B0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    load(1, mk(0, S_B1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    load(2, mk(0, S_N0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    load(3, mk(0, S_N1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    bus_in = {16'h2222, 16'h1111};
    nb_in = {32'h0, 16'h4444, 16'h3333};
    ctx_last = 4'd3;
    run = 1'b1;
    step_chk("R5", 16'h1111, 1'b1); chk("R2", "ptr", 32'(ctx_ptr), 1);
    step_chk("R5", 16'h2222, 1'b1); chk("R2", "ptr", 32'(ctx_ptr), 2);
    step_chk("R5", 16'h3333, 1'b1); chk("R2", "ptr", 32'(ctx_ptr), 3);
    step_chk("R5", 16'h4444, 1'b1); chk("R2", "ptr wrap", 32'(ctx_ptr), 0);
    step_chk("R2", 16'h1111, 1'b1); chk("R2", "ptr", 32'(ctx_ptr), 1);
    run = 1'b0;
    repeat (2) @(negedge clk);
    chk("R2", "ptr hold", 32'(ctx_ptr), 1);
    chk("R2", "data hold", 32'(data_out), 32'h1111);
  endtask

  task automatic t_rf();
    do_reset();
    load(0, mk(1, S_N2, 0, S_N3, 0, 0, 0, 1, 5, 0, 0, 0, 0, 0, 0, 0, 0));
    load(1, mk(0, S_RF, 5, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    load(2, mk(0, S_B0, 0, 0, 0, 0, 0, 1, 3, 1, S_B1, 3, 0, 0, 0, 0, 0));
    load(3, mk(0, S_B1, 0, 0, 0, 0, 0, 1, 12, 1, S_N0, 13, 0, 0, 0, 0, 0));
    load(4, mk(0, S_RF, 3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    load(5, mk(1, S_RF, 12, S_RF, 13, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    load(6, mk(1, S_RF, 5, S_B0, 0, 0, 0, 1, 5, 0, 0, 0, 0, 0, 0, 0, 0));
    load(7, mk(0, S_RF, 5, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    bus_in = {16'h0B0B, 16'h0A0A};
    nb_in = {16'h0023, 16'h0100, 16'h0000, 16'h0C0C};
    ctx_last = 4'd7;
    run = 1'b1;
    step_chk("R5", 16'h0123, 1'b1);
    step_chk("R6", 16'h0123, 1'b1);
    step_chk("R5", 16'h0A0A, 1'b1);
    step_chk("R5", 16'h0B0B, 1'b1);
    step_chk("R6", 16'h0A0A, 1'b1);
    step_chk("R6", 16'h1717, 1'b1);
    step_chk("R6", 16'h0B2D, 1'b1);
    step_chk("R6", 16'h0B2D, 1'b1);
    run = 1'b0;
  endtask

  task automatic t_rot();
    do_reset();
    load(0, mk(0, S_B0, 0, 0, 0, 0, 0, 1, 2, 0, 0, 0, 0, 0, 0, 0, 0));
    load(1, mk(0, S_RF, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    load(2, mk(0, S_RF, 2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    bus_in = {16'h0, 16'h5A5A};
    ctx_last = 4'd2;
    run = 1'b1;
    step_chk("R7", 16'h5A5A, 1'b1);
    run = 1'b0; iter_adv = 1'b1;
    @(negedge clk);
    iter_adv = 1'b0; run = 1'b1;
    step_chk("R7", 16'h5A5A, 1'b1);
    step_chk("R7", 16'h0000, 1'b0);
    run = 1'b0; iter_adv = 1'b1;
    repeat (15) @(negedge clk);
    iter_adv = 1'b0;
    load(0, mk(0, S_RF, 2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    run = 1'b1;
    step_chk("R7", 16'h5A5A, 1'b1);
    run = 1'b0;
  endtask

  task automatic t_guard();
    do_reset();
    load(0, mk(11, S_B0, 0, S_B0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0));
    load(1, mk(10, S_B0, 0, S_B0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1));
    load(2, mk(1, S_B1, 0, S_B1, 0, 0, 0, 1, 7, 0, 0, 0, 0, 1, 1, 1, 1));
    load(3, mk(0, S_RF, 7, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 2, 1, 0, 0));
    load(4, mk(1, S_B1, 0, S_B1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 3, 2, 0, 0));
    load(5, mk(0, S_B0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 3, 1, 0, 0));
    bus_in = {16'h0110, 16'h00A5};
    nb_pred = 4'b0100;
    ctx_last = 4'd5;
    run = 1'b1;
    step_chk("R9", 16'h00A5, 1'b1);
    step_chk("R9", 16'h00A5, 1'b0);
    step_chk("R8", 16'h00A5, 1'b0);
    step_chk("R8", 16'h0000, 1'b0);
    step_chk("R8", 16'h0220, 1'b1);
    step_chk("R8", 16'h0220, 1'b1);
    run = 1'b0;
  endtask

  task automatic t_prot();
    do_reset();
    load(0, mk(11, S_B0, 0, S_B0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 3));
    load(1, mk(1, S_B0, 0, S_B0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 2, 0, 0));
    load(2, mk(0, S_B1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 3, 0, 0));
    bus_in = {16'h0031, 16'h0007};
    ctx_last = 4'd2;
    run = 1'b1;
    step_chk("R9", 16'h0007, 1'b1);
    run = 1'b0; iter_adv = 1'b1;
    @(negedge clk);
    iter_adv = 1'b0; run = 1'b1;
    step_chk("R9", 16'h000E, 1'b1);
    step_chk("R9", 16'h000E, 1'b1);
    run = 1'b0;
  endtask

  task automatic t_route();
    do_reset();
    load(0, mk(0, S_B0, 0, 0, 0, 0, 0, 1, 9, 0, 0, 0, 0, 0, 0, 0, 0));
    load(1, mk(1, S_FB, 0, S_B1, 0, 0, 0, 0, 0, 1, S_RF, 10, 9, 0, 0, 0, 0));
    load(2, mk(0, S_RF, 10, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    bus_in = {16'h0101, 16'h1357};
    ctx_last = 4'd2;
    run = 1'b1;
    step_chk("R5", 16'h1357, 1'b1);
    step_chk("R11", 16'h1458, 1'b1);
    chk("R10", "route_out", 32'(route_out), 32'h1357);
    step_chk("R6", 16'h1357, 1'b1);
    chk("R10", "route_out follows register 0", 32'(route_out), 0);
    run = 1'b0;
  endtask

  initial begin
    #1600000;
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_ops();
    t_ctx();
    t_rf();
    t_rot();
    t_guard();
    t_prot();
    t_route();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule